// File: doc/BRIEF.md
# 625-Line Video Timing Generator

This block derives the complete horizontal and vertical timing of a 625-line, 64 µs-per-line interlaced video standard from a single sample-rate clock. A sample counter walks across each line and a line counter walks across the frame. Four timing outputs are decoded from the two counts: a horizontal sync pulse, a composite sync that adds broad vertical pulses at the top of each field, a window flag for the visible picture, and the current line number counted from zero.

The block also serves a line-rate standards converter. The output standard's field must begin a few input lines before the input frame starts, so that the output blanking interval has passed by the time buffered picture lines are ready. A one-cycle start pulse is raised at the first sample of a programmable input line. The line number is given on the `start_line` input, and the nominal setting is 620 (zero-based). Moving that setting absorbs the pipeline latency of the converter.

Top module: `vt625_timing`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the sample position and line are zero. So `line_num` is 0, `hsync` and `csync` are 1, `active` is 0, and `field_start` is 1 only if `start_line` is 0.
- R2: The sample position advances by one each clock from 0 to LINE_CLKS-1 (default 640), then wraps to 0. `line_num` increments at each wrap, runs 0 to FRAME_LINES-1 (624), and then returns to 0.
- R3: `hsync` is 1 exactly while the sample position is below HSYNC_CLKS (default 47, i.e. 4.7 µs), and is 0 for the rest of the line.
- R4: Field line is `line_num` in field one (lines 0 to 312) and `line_num`-313 in field two. `active` is 1 exactly when the field line is between 22 and 309 inclusive and the sample position lies in [ACT_START, ACT_START+ACT_CLKS), which is [120, 640) by default (52 µs).
- R5: On field lines 0, 1 and 2, `csync` is 1 while the sample position is below LINE_CLKS-HSYNC_CLKS and 0 for the rest of the line. On every other line `csync` equals `hsync`.
- R6: `field_start` is 1 for exactly one clock, at sample position 0 of the line whose `line_num` equals `start_line`. This happens once per frame, and it coincides with the rise of `hsync`.
- R7: A `start_line` value of FRAME_LINES (625) or more never produces `field_start`.
- R8: `start_line` is compared live. A new value takes effect at the next line that matches it, with no reset needed, and includes 0, where the pulse falls on the frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start_line | input | LINE_W (10) | Zero-based input line that triggers the output-field start |
| hsync | output | 1 | Horizontal sync, active high |
| active | output | 1 | Visible picture window |
| csync | output | 1 | Composite sync with broad vertical pulses, active high |
| line_num | output | LINE_W (10) | Current line, counted from 0 |
| field_start | output | 1 | One-cycle output-field start pulse |

## Verification
Four events can fall on the same clock: the field-start pulse, the leading edge of horizontal sync, the line increment and the frame wrap back to line 0. With `start_line` at 0, all four land together on the first sample of a broad-pulse line. The bench provokes this case, along with the nominal value 620, a field-two boundary and an out-of-range value. A behavioural model tracks the sample and line positions as integers and judges every output each cycle. Separate counts of pulses over whole-frame windows confirm one pulse per frame, or none for an out-of-range setting.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Classification of a line inside its field
    typedef enum logic [1:0] {
        SEG_BROAD   = 2'd0,
        SEG_BLANK   = 2'd1,
        SEG_PICTURE = 2'd2
    } vt_seg_e;

    // Decoded timing outputs for one sample
    typedef struct packed {
        logic hsync;
        logic active;
        logic csync;
        logic field_start;
    } vt_flags_t;

    // Position of a line inside its own field
    function automatic int fold_line(input int line, input int field1_lines,
                                     input int frame_lines);
        if (field1_lines < frame_lines && line >= field1_lines)
            return line - field1_lines;
        return line;
    endfunction

endpackage

// File: rtl/vt_hcounter.sv
module vt_hcounter #(
    parameter int LINE_CLKS = 640,
    parameter int H_W       = $clog2(LINE_CLKS)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [H_W-1:0] h_pos,
    output logic           end_of_line
);
    localparam logic [H_W-1:0] H_LAST = H_W'(LINE_CLKS - 1);

    assign end_of_line = (h_pos == H_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            h_pos <= '0;
        else if (end_of_line)
            h_pos <= '0;
        else
            h_pos <= h_pos + H_W'(1);
    end
endmodule

// File: rtl/vt_vcounter.sv
module vt_vcounter #(
    parameter int FRAME_LINES = 625,
    parameter int LINE_W      = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] L_LAST = LINE_W'(FRAME_LINES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            line <= '0;
        else if (advance) begin
            if (line == L_LAST)
                line <= '0;
            else
                line <= line + LINE_W'(1);
        end
    end
endmodule

// File: rtl/vt_lineclass.sv
module vt_lineclass
    import vt_pkg::*;
#(
    parameter int FRAME_LINES  = 625,
    parameter int FIELD1_LINES = 313,
    parameter int BROAD_LINES  = 3,
    parameter int VIS_FIRST    = 22,
    parameter int VIS_LAST     = 309,
    parameter int LINE_W       = $clog2(FRAME_LINES)
) (
    input  logic [LINE_W-1:0] line,
    output vt_seg_e           seg
);
    int field_line;

    generate
        if (FIELD1_LINES < FRAME_LINES) begin : g_interlaced
            // two fields: fold the second one onto the first
            always_comb field_line = fold_line(int'(line), FIELD1_LINES, FRAME_LINES);
        end else begin : g_progressive
            always_comb field_line = int'(line);
        end
    endgenerate

    always_comb begin
        if (field_line < BROAD_LINES)
            seg = SEG_BROAD;
        else if (field_line >= VIS_FIRST && field_line <= VIS_LAST)
            seg = SEG_PICTURE;
        else
            seg = SEG_BLANK;
    end
endmodule

// File: rtl/vt_decode.sv
module vt_decode
    import vt_pkg::*;
#(
    parameter int LINE_CLKS  = 640,
    parameter int HSYNC_CLKS = 47,
    parameter int ACT_START  = 120,
    parameter int ACT_CLKS   = 520,
    parameter int H_W        = $clog2(LINE_CLKS),
    parameter int LINE_W     = 10
) (
    input  logic [H_W-1:0]    h_pos,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] start_line,
    input  vt_seg_e           seg,
    output vt_flags_t         flags
);
    localparam int ACT_END   = ACT_START + ACT_CLKS;
    localparam int BROAD_END = LINE_CLKS - HSYNC_CLKS;

    int hv;
    assign hv = int'(h_pos);

    always_comb begin
        flags.hsync       = (hv < HSYNC_CLKS);
        flags.active      = (seg == SEG_PICTURE) && (hv >= ACT_START) && (hv < ACT_END);
        flags.csync       = (seg == SEG_BROAD) ? (hv < BROAD_END) : flags.hsync;
        flags.field_start = (hv == 0) && (line == start_line);
    end
endmodule

// File: rtl/vt625_timing.sv
module vt625_timing
    import vt_pkg::*;
#(
    parameter int LINE_CLKS    = 640,
    parameter int HSYNC_CLKS   = 47,
    parameter int ACT_START    = 120,
    parameter int ACT_CLKS     = 520,
    parameter int FRAME_LINES  = 625,
    parameter int FIELD1_LINES = 313,
    parameter int BROAD_LINES  = 3,
    parameter int VIS_FIRST    = 22,
    parameter int VIS_LAST     = 309,
    parameter int LINE_W       = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] start_line,
    output logic              hsync,
    output logic              active,
    output logic              csync,
    output logic [LINE_W-1:0] line_num,
    output logic              field_start
);
    localparam int H_W = $clog2(LINE_CLKS);

    logic [H_W-1:0]    h_pos;
    logic              eol;
    logic [LINE_W-1:0] line;
    vt_seg_e           seg;
    vt_flags_t         flags;

    vt_hcounter #(.LINE_CLKS(LINE_CLKS), .H_W(H_W)) u_h (
        .clk(clk), .rst(rst), .h_pos(h_pos), .end_of_line(eol)
    );

    vt_vcounter #(.FRAME_LINES(FRAME_LINES), .LINE_W(LINE_W)) u_v (
        .clk(clk), .rst(rst), .advance(eol), .line(line)
    );

    vt_lineclass #(
        .FRAME_LINES(FRAME_LINES), .FIELD1_LINES(FIELD1_LINES),
        .BROAD_LINES(BROAD_LINES), .VIS_FIRST(VIS_FIRST),
        .VIS_LAST(VIS_LAST), .LINE_W(LINE_W)
    ) u_cls (
        .line(line), .seg(seg)
    );

    vt_decode #(
        .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .ACT_START(ACT_START),
        .ACT_CLKS(ACT_CLKS), .H_W(H_W), .LINE_W(LINE_W)
    ) u_dec (
        .h_pos(h_pos), .line(line), .start_line(start_line), .seg(seg), .flags(flags)
    );

    assign hsync       = flags.hsync;
    assign active      = flags.active;
    assign csync       = flags.csync;
    assign field_start = flags.field_start;
    assign line_num    = line;
endmodule

// File: rtl/vt625_checker.sv
module vt625_checker #(
    parameter int FRAME_LINES  = 625,
    parameter int FIELD1_LINES = 313,
    parameter int BROAD_LINES  = 3,
    parameter int LINE_W       = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [LINE_W-1:0] start_line,
    input logic              hsync,
    input logic              active,
    input logic              csync,
    input logic [LINE_W-1:0] line_num,
    input logic              field_start
);
    int fl;
    assign fl = (int'(line_num) >= FIELD1_LINES) ? int'(line_num) - FIELD1_LINES
                                                 : int'(line_num);

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(line_num) < FRAME_LINES); // R2
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_num) |-> ((int'(line_num) == 0 && int'($past(line_num)) == FRAME_LINES - 1)
                                || int'(line_num) == int'($past(line_num)) + 1)); // R2
    AST_LINE_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_num) |-> $rose(hsync)); // R3
    AST_ACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        active |-> (!hsync && !field_start)); // R4
    AST_CSYNC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (fl >= BROAD_LINES) |-> (csync == hsync)); // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        field_start |=> !field_start); // R6
    AST_PULSE_PLACE: assert property (@(posedge clk) disable iff (rst)
        field_start |-> (hsync && line_num == start_line)); // R6
    AST_NO_PULSE_OUT: assert property (@(posedge clk) disable iff (rst)
        (int'(start_line) >= FRAME_LINES) |-> !field_start); // R7
endmodule

bind vt625_timing vt625_checker #(
    .FRAME_LINES(FRAME_LINES), .FIELD1_LINES(FIELD1_LINES),
    .BROAD_LINES(BROAD_LINES), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst(rst), .start_line(start_line), .hsync(hsync),
    .active(active), .csync(csync), .line_num(line_num), .field_start(field_start)
);

// File: tb/sim_vt625_timing.sv
`timescale 1ns/1ps
module sim_vt625_timing;
    localparam int LC = 64, HS = 5, AS = 12, AC = 52;
    localparam int FL = 625, F1 = 313, LW = 10;
    localparam int FRAME = LC * FL;

    logic clk = 0, rst = 1;
    logic [LW-1:0] start_line = 10'd620;
    logic hsync, active, csync, field_start;
    logic [LW-1:0] line_num;

    int errors = 0, checks = 0, pulses = 0;
    int rh = 0, rl = 0;
    bit armed = 0, done = 0;

    always #4 clk = ~clk;

    vt625_timing #(
        .LINE_CLKS(LC), .HSYNC_CLKS(HS), .ACT_START(AS), .ACT_CLKS(AC),
        .FRAME_LINES(FL), .FIELD1_LINES(F1)
    ) u0 (
        .clk(clk), .rst(rst), .start_line(start_line), .hsync(hsync),
        .active(active), .csync(csync), .line_num(line_num), .field_start(field_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (h=%0d line=%0d)", tag, act, exp, rh, rl);
        end
    endtask

    // behavioural reference of sample and line position
    always @(posedge clk) begin
        if (rst) begin
            rh = 0; rl = 0;
        end else if (rh == LC - 1) begin
            rh = 0;
            rl = (rl == FL - 1) ? 0 : rl + 1;
        end else
            rh = rh + 1;
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed) begin
            int fline, e_hs, e_act, e_cs, e_fs;
            fline = (rl >= F1) ? rl - F1 : rl;
            e_hs  = (rh < HS) ? 1 : 0;
            e_act = (fline >= 22 && fline <= 309 && rh >= AS && rh < AS + AC) ? 1 : 0;
            e_cs  = (fline < 3) ? ((rh < LC - HS) ? 1 : 0) : e_hs;
            e_fs  = (rh == 0 && rl == int'(start_line)) ? 1 : 0;
            if (rst) begin
                chk("R1 line_num", int'(line_num), 0);
                chk("R1 hsync", int'(hsync), 1);
                chk("R1 csync", int'(csync), 1);
                chk("R1 active", int'(active), 0);
            end else begin
                chk("R2 line_num", int'(line_num), rl);
                chk("R3 hsync", int'(hsync), e_hs);
                chk("R4 active", int'(active), e_act);
                chk("R5 csync", int'(csync), e_cs);
                chk(int'(start_line) >= FL ? "R7 field_start" : "R6 field_start",
                    int'(field_start), e_fs);
                if (field_start) pulses++;
            end
        end
    end

    task automatic frame_window(input int sl, input int exp, input string tag);
        start_line = LW'(sl);
        pulses = 0;
        repeat (FRAME) @(negedge clk);
        #2;
        chk(tag, pulses, exp);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        frame_window(620, 1, "R6 one pulse per frame at line 620");
        frame_window(0, 1, "R8 pulse on frame wrap with start 0");
        frame_window(312, 1, "R8 pulse at last line of field one");
        frame_window(700, 0, "R7 no pulse for out-of-range start");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule